// File: doc/BRIEF.md
# Command-List DMA Fetch and Execute Engine

This block is the front end of one DMA channel. Software hands it a command pointer. The pointer value is an 8-byte-aligned byte address divided by eight. From that address the engine reads pointer-list entries. Each entry either redirects the walk to another pointer list or names a chain of command entries, and the engine executes that chain. Each command is one of two kinds. A single command is a linear copy of a byte length. A box command is a two-dimensional copy: a number of rows, each of a fixed length, with a separate row stride on the source side and on the destination side.

All traffic goes through one word-wide memory port with a request/grant handshake. A read's data comes back later with a valid strobe, and only one read is in flight at a time. Data moves one 32-bit word at a time: the engine reads the word from the source, then writes it to the destination. On a side whose row stride is zero, the address stays fixed. This serves a peripheral FIFO.

When the last command of the last pointer finishes, the engine pulses `done`. A flush request stops the work early, at the next word boundary, and raises a sticky `flushed` flag instead.

Top module: `cmdlist_engine`

## Requirements
- R1: After reset `busy`, `done`, `memReq` and `flushed` are all low.
- R2: A pointer write is accepted only when the engine is idle. The first pointer entry is read at byte address `ptrWrData * 8`. A pointer write while `busy` is high has no effect on the running job and starts no second job.
- R3: Pointer-entry format. Bit 31 marks the last pointer. Bit 29 set makes the entry a redirect: the walk continues at the target as a new pointer list, and bit 31 of that entry is ignored. Bits [28:0] hold the target byte address divided by 8. After the command chain of a non-last pointer ends, the next entry is read 4 bytes further on.
- R4: Command word format. Bit 31 marks the last command. Bits [1:0] equal to 3 select a box, and any other value selects a single. A single takes 4 consecutive words (command, source, destination, length in bits [15:0]). A box takes 6 (command, source, destination, row length, row count, row stride). The next command follows directly after.
- R5: A single copies ceil(length/4) words. Both the source and destination addresses step by 4 per word.
- R6: A single of length 0, or a box with a zero row count or zero row length, finishes without any memory write. The chain then continues.
- R7: In a box, the row length in bytes and the row count are taken from bits [31:16] of their words. Each row moves ceil(row length/4) words. The row stride word holds the source stride in bits [31:16] and the destination stride in bits [15:0].
- R8: On a box side with a nonzero stride, the address steps by 4 inside a row, and each row starts at the previous row's start plus the stride. On a side with a zero stride, every access uses the same address.
- R9: Every data word is one source read followed by one destination write of the returned data. After a read is granted, no request is made until its data has returned.
- R10: After the final command of the final pointer, `done` is high for exactly one cycle and `busy` is low on the next cycle.
- R11: A flush request while busy stops the job before the next read is issued. The word in progress is still written. `busy` drops, `done` does not pulse, and `flushed` goes high. `flushed` stays high until the next accepted pointer write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ptrWrEn | input | 1 | Command pointer write strobe |
| ptrWrData | input | AW-3 | Pointer-list address divided by 8 |
| flushReq | input | 1 | Abort request |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the request |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-cycle completion pulse |
| flushed | output | 1 | Sticky flag: last job was aborted |

## Verification
The bench drives the engine against a memory model whose grant is withheld one cycle in three. Expected contents are computed from word indices, so ordering and addressing slips become visible.

Singles with lengths of 16, 10 and 0 separate correct word rounding from overrun and from a skipped empty command. Boxes are run in three ways: from a fixed read FIFO into strided memory, from strided memory into a fixed write FIFO, and with a rounded row length and unequal strides on both sides. Together these tell the source and destination strides apart, show which half-word is used, and check the fixed-address behaviour.

A redirect followed by a two-entry pointer list checks list walking. A pointer write in mid-job and a mid-job flush check that control inputs are ignored or honoured at the right moments.

// File: rtl/cle_pkg.sv
package cle_pkg;

  // Field positions shared by control and datapath
  localparam int PTR_LAST_BIT = 31;
  localparam int PTR_NEST_BIT = 29;
  localparam int CMD_LAST_BIT = 31;
  localparam logic [1:0] TYPE_BOX = 2'b11;
  localparam int SINGLE_WORDS = 4;
  localparam int BOX_WORDS = 6;
  localparam int IDX_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_PTR,
    ST_FETCH_CMD,
    ST_ARM,
    ST_EXEC_RD,
    ST_EXEC_WR,
    ST_NEXT,
    ST_DONE
  } cleState_e;

  typedef enum logic [1:0] {
    SEL_PTR,
    SEL_CMD,
    SEL_SRC,
    SEL_DST
  } addrSel_e;

  typedef struct packed {
    logic loadPtr;
    logic ptrCapture;
    logic ptrStep;
    logic cmdCapture;
    logic [IDX_W-1:0] cmdIdx;
    logic arm;
    logic dataCapture;
    logic wordDone;
    addrSel_e addrSel;
  } cleStrobe_t;

endpackage

// File: rtl/cle_ctrl.sv
module cle_ctrl
  import cle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ptrWrEn,
  input  logic       flushReq,
  input  logic       memGnt,
  input  logic       memRvalid,
  input  logic       entryNested,
  input  logic       ptrIsLast,
  input  logic       cmdIsBox,
  input  logic       cmdIsLast,
  input  logic       armEmpty,
  input  logic       lastWord,
  output cleStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done,
  output logic       flushed
);

  localparam logic [IDX_W-1:0] LAST_SINGLE_IDX = IDX_W'(SINGLE_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_BOX_IDX    = IDX_W'(BOX_WORDS - 1);

  cleState_e state, stateNxt;
  logic waitR;
  logic [IDX_W-1:0] idx;
  logic flushPend;
  logic flushedR;

  logic rdState, abortNow, got, finalWord, rdAccept;

  assign rdState   = (state == ST_FETCH_PTR) || (state == ST_FETCH_CMD) || (state == ST_EXEC_RD);
  assign abortNow  = rdState && !waitR && flushPend;
  assign got       = waitR && memRvalid;
  assign finalWord = (idx == LAST_BOX_IDX) || ((idx == LAST_SINGLE_IDX) && !cmdIsBox);

  assign memReq   = (rdState && !waitR && !flushPend) || (state == ST_EXEC_WR);
  assign memWe    = (state == ST_EXEC_WR);
  assign rdAccept = memReq && memGnt && !memWe;

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign flushed = flushedR;

  always_comb begin
    stb             = '0;
    stb.loadPtr     = (state == ST_IDLE) && ptrWrEn;
    stb.ptrCapture  = (state == ST_FETCH_PTR) && got;
    stb.ptrStep     = (state == ST_NEXT) && cmdIsLast && !ptrIsLast;
    stb.cmdCapture  = (state == ST_FETCH_CMD) && got;
    stb.cmdIdx      = idx;
    stb.arm         = (state == ST_ARM);
    stb.dataCapture = (state == ST_EXEC_RD) && got;
    stb.wordDone    = (state == ST_EXEC_WR) && memGnt;
    unique case (state)
      ST_FETCH_PTR: stb.addrSel = SEL_PTR;
      ST_FETCH_CMD: stb.addrSel = SEL_CMD;
      ST_EXEC_WR:   stb.addrSel = SEL_DST;
      default:      stb.addrSel = SEL_SRC;
    endcase
  end

  always_comb begin
    stateNxt = state;
    if (abortNow) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:      if (ptrWrEn) stateNxt = ST_FETCH_PTR;
        ST_FETCH_PTR: if (got) stateNxt = entryNested ? ST_FETCH_PTR : ST_FETCH_CMD;
        ST_FETCH_CMD: if (got && finalWord) stateNxt = ST_ARM;
        ST_ARM:       stateNxt = armEmpty ? ST_NEXT : ST_EXEC_RD;
        ST_EXEC_RD:   if (got) stateNxt = ST_EXEC_WR;
        ST_EXEC_WR:   if (memGnt) stateNxt = lastWord ? ST_NEXT : ST_EXEC_RD;
        ST_NEXT:      stateNxt = !cmdIsLast ? ST_FETCH_CMD : (ptrIsLast ? ST_DONE : ST_FETCH_PTR);
        ST_DONE:      stateNxt = ST_IDLE;
        default:      stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitR     <= 1'b0;
      idx       <= '0;
      flushPend <= 1'b0;
      flushedR  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (rdAccept)       waitR <= 1'b1;
      else if (memRvalid) waitR <= 1'b0;
      if (state != ST_FETCH_CMD)         idx <= '0;
      else if (got && finalWord)         idx <= '0;
      else if (got)                      idx <= idx + 1'b1;
      if (state == ST_IDLE) flushPend <= 1'b0;
      else if (flushReq)    flushPend <= 1'b1;
      if (abortNow)         flushedR <= 1'b1;
      else if (stb.loadPtr) flushedR <= 1'b0;
    end
  end

  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && !memWe) |=> !memReq);

  // R11
  flushed_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushed |-> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: rtl/cle_dpath.sv
module cle_dpath
  import cle_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  cleStrobe_t    stb,
  input  logic [AW-4:0] ptrWrData,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic          entryNested,
  output logic          ptrIsLast,
  output logic          cmdIsBox,
  output logic          cmdIsLast,
  output logic          armEmpty,
  output logic          lastWord
);

  localparam int PW = AW - 3;
  localparam int LW = 16;
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [AW-1:0] ptrCur, cmdCur, srcBase, dstBase;
  logic [AW-1:0] srcPtr, dstPtr, srcRow, dstRow;
  logic          ptrLastR, cmdLastR;
  logic [1:0]    cmdTypeR;
  logic [31:0]   lenWord, offWord;
  logic [LW-1:0] rowCntR;
  logic [LW-1:0] wordsLeft, rowsLeft, rowWords;
  logic [31:0]   dataR;

  logic [AW-1:0] entryTgt;
  logic [LW-1:0] rowBytes, rowWordsC, rowsC, srcOff, dstOff;
  logic          srcInc, dstInc;

  assign entryTgt    = {memRdata[PW-1:0], 3'b000};
  assign entryNested = memRdata[PTR_NEST_BIT];
  assign ptrIsLast   = ptrLastR;
  assign cmdIsBox    = (cmdTypeR == TYPE_BOX);
  assign cmdIsLast   = cmdLastR;

  assign rowBytes  = cmdIsBox ? lenWord[31:16] : lenWord[15:0];
  assign rowWordsC = LW'(({1'b0, rowBytes} + 17'd3) >> 2);
  assign rowsC     = cmdIsBox ? rowCntR : LW'(1);
  assign srcOff    = cmdIsBox ? offWord[31:16] : '0;
  assign dstOff    = cmdIsBox ? offWord[15:0] : '0;
  assign srcInc    = !cmdIsBox || (srcOff != '0);
  assign dstInc    = !cmdIsBox || (dstOff != '0);
  assign armEmpty  = (rowWordsC == '0) || (rowsC == '0);
  assign lastWord  = (wordsLeft == LW'(1)) && (rowsLeft == LW'(1));

  always_comb begin
    unique case (stb.addrSel)
      SEL_PTR: memAddr = ptrCur;
      SEL_CMD: memAddr = cmdCur;
      SEL_SRC: memAddr = srcPtr;
      default: memAddr = dstPtr;
    endcase
  end
  assign memWdata = dataR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrCur    <= '0;
      cmdCur    <= '0;
      ptrLastR  <= 1'b0;
      cmdLastR  <= 1'b0;
      cmdTypeR  <= '0;
      srcBase   <= '0;
      dstBase   <= '0;
      lenWord   <= '0;
      rowCntR   <= '0;
      offWord   <= '0;
      srcPtr    <= '0;
      dstPtr    <= '0;
      srcRow    <= '0;
      dstRow    <= '0;
      wordsLeft <= '0;
      rowsLeft  <= '0;
      rowWords  <= '0;
      dataR     <= '0;
    end else begin
      if (stb.loadPtr) ptrCur <= {ptrWrData, 3'b000};
      if (stb.ptrStep) ptrCur <= ptrCur + WORD_STEP;
      if (stb.ptrCapture) begin
        if (memRdata[PTR_NEST_BIT]) begin
          ptrCur <= entryTgt;
        end else begin
          cmdCur   <= entryTgt;
          ptrLastR <= memRdata[PTR_LAST_BIT];
        end
      end
      if (stb.cmdCapture) begin
        cmdCur <= cmdCur + WORD_STEP;
        unique case (stb.cmdIdx)
          3'd0: begin
            cmdLastR <= memRdata[CMD_LAST_BIT];
            cmdTypeR <= memRdata[1:0];
          end
          3'd1:    srcBase <= memRdata[AW-1:0];
          3'd2:    dstBase <= memRdata[AW-1:0];
          3'd3:    lenWord <= memRdata;
          3'd4:    rowCntR <= memRdata[31:16];
          default: offWord <= memRdata;
        endcase
      end
      if (stb.arm) begin
        srcPtr    <= srcBase;
        srcRow    <= srcBase;
        dstPtr    <= dstBase;
        dstRow    <= dstBase;
        wordsLeft <= rowWordsC;
        rowWords  <= rowWordsC;
        rowsLeft  <= rowsC;
      end
      if (stb.dataCapture) dataR <= memRdata;
      if (stb.wordDone) begin
        if (wordsLeft == LW'(1)) begin
          rowsLeft  <= rowsLeft - 1'b1;
          wordsLeft <= rowWords;
          srcRow    <= srcRow + AW'(srcOff);
          dstRow    <= dstRow + AW'(dstOff);
          srcPtr    <= srcRow + AW'(srcOff);
          dstPtr    <= dstRow + AW'(dstOff);
        end else begin
          wordsLeft <= wordsLeft - 1'b1;
          srcPtr    <= srcPtr + (srcInc ? WORD_STEP : '0);
          dstPtr    <= dstPtr + (dstInc ? WORD_STEP : '0);
        end
      end
    end
  end

  // R8
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wordDone && cmdIsBox && (srcOff == '0)) |=> (srcPtr == $past(srcPtr)));

  // R8
  dst_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wordDone && cmdIsBox && (dstOff == '0)) |=> (dstPtr == $past(dstPtr)));

  // R6
  no_empty_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordDone |-> ((wordsLeft != '0) && (rowsLeft != '0)));

endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine
  import cle_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ptrWrEn,
  input  logic [AW-4:0] ptrWrData,
  input  logic          flushReq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic          memGnt,
  input  logic          memRvalid,
  input  logic [31:0]   memRdata,
  output logic          busy,
  output logic          done,
  output logic          flushed
);

  cleStrobe_t stb;
  logic entryNested, ptrIsLast, cmdIsBox, cmdIsLast, armEmpty, lastWord;

  cle_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .flushReq(flushReq),
    .memGnt(memGnt), .memRvalid(memRvalid), .entryNested(entryNested),
    .ptrIsLast(ptrIsLast), .cmdIsBox(cmdIsBox), .cmdIsLast(cmdIsLast),
    .armEmpty(armEmpty), .lastWord(lastWord), .stb(stb),
    .memReq(memReq), .memWe(memWe), .busy(busy), .done(done), .flushed(flushed)
  );

  cle_dpath #(.AW(AW)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ptrWrData(ptrWrData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .entryNested(entryNested), .ptrIsLast(ptrIsLast), .cmdIsBox(cmdIsBox),
    .cmdIsLast(cmdIsLast), .armEmpty(armEmpty), .lastWord(lastWord)
  );

endmodule

// File: tb/cmdlist_engine_tb_top.sv
module cmdlist_engine_tb_top;

  localparam int AW = 32;
  localparam logic [31:0] FIFO_RD = 32'h0000_2000;
  localparam logic [31:0] FIFO_WR = 32'h0000_3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ptrWrEn = 1'b0;
  logic [AW-4:0] ptrWrData = '0;
  logic flushReq = 1'b0;
  logic memReq, memWe, busy, done, flushed;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic memGnt = 1'b0;
  logic memRvalid = 1'b0;
  logic [31:0] memRdata = '0;

  always #2 clk = ~clk;

  cmdlist_engine #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .flushReq(flushReq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memGnt(memGnt), .memRvalid(memRvalid),
    .memRdata(memRdata), .busy(busy), .done(done), .flushed(flushed)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] wlog [0:63];
  int wlogN = 0, totalWr = 0, srcReads = 0, doneCnt = 0, fifoRdCnt = 0, gntCnt = 0;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    gntCnt <= gntCnt + 1;
    memGnt <= ((gntCnt % 3) != 2);
    memRvalid <= 1'b0;
    if (done) doneCnt <= doneCnt + 1;
    if (rstN && memReq && memGnt) begin
      if (memWe) begin
        totalWr <= totalWr + 1;
        if (memAddr == FIFO_WR) begin
          wlog[wlogN[5:0]] <= memWdata;
          wlogN <= wlogN + 1;
        end else begin
          mem[memAddr[11:2]] <= memWdata;
        end
      end else begin
        memRvalid <= 1'b1;
        if (memAddr == FIFO_RD) begin
          memRdata <= 32'(fifoRdCnt);
          fifoRdCnt <= fifoRdCnt + 1;
          srcReads <= srcReads + 1;
        end else begin
          memRdata <= mem[memAddr[11:2]];
          if (memAddr >= 32'h400 && memAddr < 32'h800) srcReads <= srcReads + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] srcVal(input int i);
    return 32'hA500_0000 + 32'(i);
  endfunction

  function automatic logic [31:0] ptrE(input bit last, input bit nest, input logic [31:0] tgt);
    return ({31'b0, last} << 31) | ({31'b0, nest} << 29) | (tgt >> 3);
  endfunction

  task automatic putW(input logic [31:0] a, input logic [31:0] v);
    mem[a[11:2]] = v;
  endtask

  task automatic putSingle(input logic [31:0] a, input bit last, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] len);
    putW(a, {last, 29'b0, 2'b00});
    putW(a + 4, s);
    putW(a + 8, d);
    putW(a + 12, len);
  endtask

  task automatic putBox(input logic [31:0] a, input bit last, input logic [31:0] s,
                        input logic [31:0] d, input logic [15:0] rlen, input logic [15:0] rows,
                        input logic [15:0] sOff, input logic [15:0] dOff);
    putW(a, {last, 29'b0, 2'b11});
    putW(a + 4, s);
    putW(a + 8, d);
    putW(a + 12, {rlen, rlen});
    putW(a + 16, {rows, rows});
    putW(a + 20, {sOff, dOff});
  endtask

  task automatic clearDst();
    for (int i = 512; i < 1024; i++) mem[i] = 32'h0;
  endtask

  function automatic logic [31:0] dstW(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic startJob(input logic [31:0] a);
    @(negedge clk);
    ptrWrEn = 1'b1;
    ptrWrData = a[31:3];
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  task automatic waitDone(input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, req, 32'(seen), 32'd1);
    @(negedge clk);
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog R10 act=%h exp=%h", 32'd0, 32'd1);
    finishUp();
  end

  initial begin
    int w0, r0, d0, f0, l0, w;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int i = 0; i < 256; i++) mem[256 + i] = srcVal(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(done == 0, "R1 done", 32'(done), 0);
    chk(memReq == 0, "R1 memReq", 32'(memReq), 0);
    chk(flushed == 0, "R1 flushed", 32'(flushed), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // A: single of 16 bytes, pointer at 0x018 (R2 address = value*8)
    putW(32'h018, ptrE(1, 0, 32'h100));
    putSingle(32'h100, 1, 32'h400, 32'h800, 16);
    clearDst();
    w0 = totalWr; r0 = srcReads; d0 = doneCnt;
    startJob(32'h018);
    waitDone("R10 done A");
    for (int i = 0; i < 4; i++) chk(dstW(32'h800 + 4 * i) == srcVal(i), "R5 copy", dstW(32'h800 + 4 * i), srcVal(i));
    chk(dstW(32'h810) == 0, "R5 no overrun", dstW(32'h810), 0);
    chk(totalWr - w0 == 4, "R9 writes", 32'(totalWr - w0), 4);
    chk(srcReads - r0 == 4, "R9 reads", 32'(srcReads - r0), 4);
    chk(doneCnt - d0 == 1, "R10 one pulse", 32'(doneCnt - d0), 1);
    chk(busy == 0, "R10 idle", 32'(busy), 0);

    // B: single of 10 bytes -> 3 words (R5 rounding)
    putW(32'h000, ptrE(1, 0, 32'h100));
    putSingle(32'h100, 1, 32'h440, 32'h800, 10);
    clearDst();
    startJob(32'h000);
    waitDone("R10 done B");
    for (int i = 0; i < 3; i++) chk(dstW(32'h800 + 4 * i) == srcVal(16 + i), "R5 round", dstW(32'h800 + 4 * i), srcVal(16 + i));
    chk(dstW(32'h80C) == 0, "R5 round stop", dstW(32'h80C), 0);

    // C: empty single, empty box, then a real single (R4 chaining, R6)
    putSingle(32'h100, 0, 32'h400, 32'h900, 0);
    putBox(32'h110, 0, 32'h400, 32'h900, 16, 0, 4, 4);
    putSingle(32'h128, 1, 32'h480, 32'h800, 8);
    clearDst();
    w0 = totalWr;
    startJob(32'h000);
    waitDone("R6 done C");
    chk(totalWr - w0 == 2, "R6 no writes from empty", 32'(totalWr - w0), 2);
    chk(dstW(32'h800) == srcVal(32) && dstW(32'h804) == srcVal(33), "R4 chain", dstW(32'h804), srcVal(33));
    chk(dstW(32'h900) == 0, "R6 empty dst untouched", dstW(32'h900), 0);

    // D: box from fixed read FIFO into strided memory (R7, R8)
    putBox(32'h100, 1, FIFO_RD, 32'h800, 8, 3, 0, 12);
    clearDst();
    f0 = fifoRdCnt;
    startJob(32'h000);
    waitDone("R7 done D");
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 2; k++)
        chk(dstW(32'h800 + 12 * r + 4 * k) == 32'(f0 + 2 * r + k), "R8 fifo-to-mem",
            dstW(32'h800 + 12 * r + 4 * k), 32'(f0 + 2 * r + k));
    chk(dstW(32'h808) == 0 && dstW(32'h814) == 0, "R7 stride gap", dstW(32'h808), 0);
    chk(fifoRdCnt - f0 == 6, "R8 fifo reads", 32'(fifoRdCnt - f0), 6);

    // E: box from strided memory into fixed write FIFO (R8)
    putBox(32'h100, 1, 32'h400, FIFO_WR, 12, 2, 16, 0);
    l0 = wlogN;
    startJob(32'h000);
    waitDone("R8 done E");
    chk(wlogN - l0 == 6, "R8 fifo writes", 32'(wlogN - l0), 6);
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 3; k++)
        chk(wlog[l0 + 3 * r + k] == srcVal(4 * r + k), "R8 mem-to-fifo", wlog[l0 + 3 * r + k], srcVal(4 * r + k));

    // F: box with rounded row length and unequal strides (R7, R8)
    putBox(32'h100, 1, 32'h400, 32'h800, 6, 2, 8, 16);
    clearDst();
    startJob(32'h000);
    waitDone("R7 done F");
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 2; k++)
        chk(dstW(32'h800 + 16 * r + 4 * k) == srcVal(2 * r + k), "R7 box strides",
            dstW(32'h800 + 16 * r + 4 * k), srcVal(2 * r + k));
    chk(dstW(32'h808) == 0, "R7 row length rounding", dstW(32'h808), 0);

    // G: redirect entry (bit 31 set, ignored) then two-entry list (R3)
    putW(32'h000, ptrE(1, 1, 32'h040));
    putW(32'h040, ptrE(0, 0, 32'h100));
    putW(32'h044, ptrE(1, 0, 32'h180));
    putSingle(32'h100, 1, 32'h400, 32'h800, 8);
    putSingle(32'h180, 1, 32'h410, 32'h820, 8);
    clearDst();
    d0 = doneCnt;
    startJob(32'h000);
    waitDone("R3 done G");
    chk(dstW(32'h804) == srcVal(1), "R3 first list", dstW(32'h804), srcVal(1));
    chk(dstW(32'h824) == srcVal(5), "R3 second list", dstW(32'h824), srcVal(5));
    chk(doneCnt - d0 == 1, "R3 single done", 32'(doneCnt - d0), 1);

    // H: pointer write while busy is ignored (R2)
    putW(32'h000, ptrE(1, 0, 32'h100));
    putW(32'h008, ptrE(1, 0, 32'h180));
    putSingle(32'h100, 1, 32'h400, 32'h800, 256);
    putSingle(32'h180, 1, 32'h400, 32'hC00, 16);
    clearDst();
    w0 = totalWr; d0 = doneCnt;
    startJob(32'h000);
    repeat (20) @(negedge clk);
    startJob(32'h008);
    waitDone("R2 done H");
    repeat (20) @(negedge clk);
    chk(dstW(32'hC00) == 0, "R2 ignored pointer", dstW(32'hC00), 0);
    chk(doneCnt - d0 == 1, "R2 one job", 32'(doneCnt - d0), 1);
    chk(totalWr - w0 == 64, "R2 full job", 32'(totalWr - w0), 64);
    chk(dstW(32'h8FC) == srcVal(63), "R5 long copy", dstW(32'h8FC), srcVal(63));

    // I: flush mid-job (R11)
    clearDst();
    w0 = totalWr; r0 = srcReads; d0 = doneCnt;
    startJob(32'h000);
    repeat (60) @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    w = totalWr - w0;
    chk(busy == 0, "R11 stopped", 32'(busy), 0);
    chk(flushed == 1, "R11 flag", 32'(flushed), 1);
    chk(doneCnt == d0, "R11 no done", 32'(doneCnt - d0), 0);
    chk(w > 0 && w < 64, "R11 partial", 32'(w), 32);
    chk(srcReads - r0 == w, "R11 whole words", 32'(srcReads - r0), 32'(w));
    if (w > 0 && w < 64) begin
      chk(dstW(32'h800 + 4 * (w - 1)) == srcVal(w - 1), "R11 last word", dstW(32'h800 + 4 * (w - 1)), srcVal(w - 1));
      chk(dstW(32'h800 + 4 * w) == 0, "R11 nothing after", dstW(32'h800 + 4 * w), 0);
    end

    // flag cleared by next accepted pointer write (R11)
    putSingle(32'h100, 1, 32'h400, 32'h800, 16);
    startJob(32'h000);
    chk(flushed == 0, "R11 cleared", 32'(flushed), 0);
    waitDone("R11 done after flush");
    chk(dstW(32'h80C) == srcVal(3), "R11 restart copy", dstW(32'h80C), srcVal(3));

    finishUp();
  end

endmodule